// File: doc/BRIEF.md
# DMA Deadlock Watchdog

This block watches a multi-channel DMA engine for a starvation deadlock. In that state no channel can move data. Both the load queue and the store queue are empty, and every channel that is running is kept from issuing its next load. A channel is kept from loading when the shared data FIFO has no room for its load, or when some other channel holds the load lock. Channels that are not running take no part in the decision. When no channel is running, the block never reports a deadlock.

A counter measures how long the deadlock lasts. It advances on each clock edge at which the deadlock is present and clears on any edge at which it is absent. When the run length reaches a threshold given on an input port, the block issues a one-cycle timeout pulse. That pulse feeds the engine's imprecise-abort path. The counter then starts again from zero, so a deadlock that persists produces one pulse per threshold period. A threshold of zero turns the watchdog off. Choosing which channel to abort is left to the logic that receives the pulse.

Top module: `lkwd_top`

## Requirements
- R1: `stall_o` is 0 whenever `ldq_empty_i` is 0.
- R2: `stall_o` is 0 whenever `stq_empty_i` is 0.
- R3: A running channel i whose bit in `nospace_i` is 1 counts as blocked.
- R4: A running channel i also counts as blocked when `lock_held_i` is 1 and `lock_id_i` differs from i. When the lock holder is i itself, or `lock_held_i` is 0, `lock_id_i` does not block channel i.
- R5: `stall_o` is 1 exactly when both queues are empty, at least one bit of `run_i` is set, and every channel whose `run_i` bit is set is blocked. Channels whose `run_i` bit is 0 have no effect.
- R6: When `run_i` is all zeros, `stall_o` and `timeout_o` stay 0 whatever the other inputs are.
- R7: If `stall_o` is 1 at N consecutive rising edges, where N = `thr_i` and N >= 1, then `timeout_o` is 1 for the cycle that follows the N-th edge.
- R8: An edge at which `stall_o` is 0 clears the run length, so a later timeout needs a fresh full run of N edges.
- R9: After a pulse the count restarts from zero. A deadlock that persists gives one pulse every N cycles, and each pulse lasts one cycle when N > 1.
- R10: While `thr_i` is 0, `timeout_o` stays 0 and the count is held at zero.
- R11: While `rst_ni` is low, and in the first cycle after it is released, `timeout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ldq_empty_i | input | 1 | Load queue is empty |
| stq_empty_i | input | 1 | Store queue is empty |
| run_i | input | NCH | Per-channel running mask |
| nospace_i | input | NCH | Per-channel: FIFO lacks room for this channel's load |
| lock_held_i | input | 1 | Some channel holds the load lock |
| lock_id_i | input | IDW | Index of the lock-holding channel (IDW = clog2(NCH), minimum 1) |
| thr_i | input | CW | Timeout threshold in cycles; 0 disables |
| stall_o | output | 1 | Deadlock condition present this cycle (combinational) |
| timeout_o | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Two actions can fall on the same clock edge: the expiry of a window and the restart of the counter while the deadlock continues. The bench provokes this by holding a deadlock for several threshold periods, including a threshold of one, where a pulse is due on every edge. It expects a pulse at exactly every N-th edge. The case where the deadlock clears on the edge right after an expiry is also exercised. A reference model in the bench steps edge by edge and judges both cases, alongside random queue, lock and FIFO-space patterns and threshold changes made in the middle of a run.

// File: rtl/lkwd_pkg.sv
package lkwd_pkg;
   // Width of a channel index; at least one bit
   function automatic int id_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lkwd_chan.sv
module lkwd_chan #(
   parameter int IDW = 2,
   parameter int IDX = 0
) (
   input  logic           run_i,
   input  logic           nospace_i,
   input  logic           lock_held_i,
   input  logic [IDW-1:0] lock_id_i,
   output logic           clear_o    // channel is idle or cannot load
);
   logic other_owns;
   logic blocked;

   assign other_owns = lock_held_i && (lock_id_i != IDW'(IDX));
   assign blocked    = nospace_i || other_owns;
   assign clear_o    = !run_i || blocked;

   // R4
   own_lock_free_chk: assert final (!(run_i && !nospace_i && lock_held_i &&
                                      lock_id_i == IDW'(IDX)) || !clear_o);
endmodule

// File: rtl/lkwd_cond.sv
module lkwd_cond #(
   parameter int NCH = 4
) (
   input  logic           ldq_empty_i,
   input  logic           stq_empty_i,
   input  logic [NCH-1:0] run_i,
   input  logic [NCH-1:0] clear_i,
   output logic           stall_o
);
   logic any_run;
   logic all_clear;

   assign any_run   = |run_i;
   assign all_clear = &clear_i;
   assign stall_o   = ldq_empty_i && stq_empty_i && any_run && all_clear;

   // R6
   idle_no_stall_chk: assert final (run_i != '0 || !stall_o);
   // R1
   ldq_busy_chk: assert final (ldq_empty_i || !stall_o);
   // R2
   stq_busy_chk: assert final (stq_empty_i || !stall_o);
endmodule

// File: rtl/lkwd_timer.sv
module lkwd_timer #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cond_i,
   input  logic [CW-1:0] thr_i,
   output logic          pulse_o
);
   logic [CW-1:0] cnt_q;
   logic [CW:0]   nxt;
   logic          pulse_q;
   logic          off;

   assign nxt     = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
   assign off     = (thr_i == '0);
   assign pulse_o = pulse_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (!cond_i || off) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else if (nxt >= {1'b0, thr_i}) begin
         cnt_q   <= '0;
         pulse_q <= 1'b1;
      end else begin
         cnt_q   <= nxt[CW-1:0];
         pulse_q <= 1'b0;
      end
   end

   // R7
   pulse_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |-> $past(cond_i));
   // R10
   disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      off |=> !pulse_q);
   // R8
   clear_on_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cond_i |=> (cnt_q == '0 && !pulse_q));
   // R9
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |=> (!pulse_q || $past(thr_i) == {{(CW-1){1'b0}}, 1'b1}));
   // R9
   restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |-> cnt_q == '0);
endmodule

// File: rtl/lkwd_top.sv
module lkwd_top import lkwd_pkg::*; #(
   parameter int NCH = 4,
   parameter int CW  = 8,
   localparam int IDW = id_width(NCH)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           ldq_empty_i,
   input  logic           stq_empty_i,
   input  logic [NCH-1:0] run_i,
   input  logic [NCH-1:0] nospace_i,
   input  logic           lock_held_i,
   input  logic [IDW-1:0] lock_id_i,
   input  logic [CW-1:0]  thr_i,
   output logic           stall_o,
   output logic           timeout_o
);
   if (NCH < 1) begin : g_bad_nch
      $error("lkwd_top: NCH must be at least 1");
   end
   if (CW < 1 || CW > 31) begin : g_bad_cw
      $error("lkwd_top: CW must lie in 1..31");
   end

   logic [NCH-1:0] clear;
   logic           stall;

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      lkwd_chan #(.IDW(IDW), .IDX(i)) u_chan (
         .run_i       (run_i[i]),
         .nospace_i   (nospace_i[i]),
         .lock_held_i (lock_held_i),
         .lock_id_i   (lock_id_i),
         .clear_o     (clear[i])
      );
   end

   lkwd_cond #(.NCH(NCH)) u_cond (
      .ldq_empty_i (ldq_empty_i),
      .stq_empty_i (stq_empty_i),
      .run_i       (run_i),
      .clear_i     (clear),
      .stall_o     (stall)
   );

   lkwd_timer #(.CW(CW)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (stall),
      .thr_i   (thr_i),
      .pulse_o (timeout_o)
   );

   assign stall_o = stall;

   // R6
   idle_no_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i == '0) |=> !timeout_o);
endmodule

// File: tb/sim_lkwd_top.sv
module sim_lkwd_top;
   localparam int NCH = 4;
   localparam int CW  = 8;
   localparam int IDW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ldq_e = 1'b1, stq_e = 1'b1;
   logic [NCH-1:0] run = '0, nosp = '0;
   logic           lk_held = 1'b0;
   logic [IDW-1:0] lk_id = '0;
   logic [CW-1:0]  thr = 8'd3;
   logic           stall, tmo;

   int n_chk = 0, n_bad = 0;
   int m_cnt = 0;
   bit m_tmo = 0;

   always #5 clk = ~clk;

   lkwd_top #(.NCH(NCH), .CW(CW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .ldq_empty_i(ldq_e), .stq_empty_i(stq_e),
      .run_i(run), .nospace_i(nosp), .lock_held_i(lk_held), .lock_id_i(lk_id),
      .thr_i(thr), .stall_o(stall), .timeout_o(tmo));

   function automatic bit cond_f();
      bit ok = 1;
      if (!ldq_e || !stq_e || run == '0) return 0;
      for (int i = 0; i < NCH; i++)
         if (run[i] && !(nosp[i] || (lk_held && int'(lk_id) != i))) ok = 0;
      return ok;
   endfunction

   task automatic chk(input string tag, input logic act, input bit exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a negedge with inputs already set
   task automatic tick(input string tag);
      bit c;
      #1;
      c = cond_f();
      chk({tag, " stall"}, stall, c);
      @(posedge clk);
      if (!c || thr == '0) begin m_cnt = 0; m_tmo = 0; end
      else if (m_cnt + 1 >= int'(thr)) begin m_cnt = 0; m_tmo = 1; end
      else begin m_cnt++; m_tmo = 0; end
      #1;
      chk({tag, " timeout"}, tmo, m_tmo);
      @(negedge clk);
   endtask

   task automatic deadlock();
      ldq_e = 1; stq_e = 1; run = 4'b0011; nosp = 4'b0011; lk_held = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      deadlock();
      repeat (3) @(negedge clk);
      #1 chk("R11 in reset", tmo, 0);
      rst_n = 1;
      @(negedge clk);
      tick("R11 first cycle");  // thr=3 so no pulse yet
      m_cnt = 0;
      rst_n = 0; @(negedge clk); rst_n = 1;

      // R6: nothing running, all else stalling
      run = '0; nosp = '1; lk_held = 1; lk_id = 2'd1; thr = 8'd1;
      for (int k = 0; k < 5; k++) tick("R6 idle");
      // R4: single channel, own lock vs foreign lock vs no lock
      run = 4'b0001; nosp = '0; lk_held = 1; lk_id = 2'd0; thr = 8'd4;
      tick("R4 own lock");
      lk_id = 2'd2; tick("R4 other lock");
      lk_held = 0; tick("R4 lock not held");
      // R5: ch1 free while ch0 blocked; idle ch3 free is ignored
      run = 4'b0011; nosp = 4'b0001; tick("R5 one free");
      nosp = 4'b0011; tick("R5 idle ignored");
      // R3 with R1/R2 breaks
      ldq_e = 0; tick("R1 load busy");
      ldq_e = 1; stq_e = 0; tick("R2 store busy");
      // R7 R9: hold over three periods of 3
      deadlock(); thr = 8'd3; m_cnt = 0;
      rst_n = 0; @(negedge clk); rst_n = 1;
      for (int k = 0; k < 9; k++) tick("R7 R9 hold");
      // clear right after expiry
      run = '0; tick("R9 clear after pulse");
      // R8: gap resets count
      deadlock();
      tick("R8 a"); tick("R8 b");
      ldq_e = 0; tick("R8 gap");
      ldq_e = 1;
      for (int k = 0; k < 3; k++) tick("R8 fresh run");
      // thr=1: pulse every edge
      thr = 8'd1;
      for (int k = 0; k < 4; k++) tick("R9 thr1");
      // R10
      thr = 8'd0;
      for (int k = 0; k < 10; k++) tick("R10 disabled");
      thr = 8'd2;
      for (int k = 0; k < 4; k++) tick("R10 re-enabled");

      // Random phase, biased toward deadlock
      for (int k = 0; k < 4000; k++) begin
         if (k % 150 == 0) thr = CW'($urandom_range(0, 6));
         ldq_e   = ($urandom_range(0, 9) != 0);
         stq_e   = ($urandom_range(0, 9) != 0);
         run     = NCH'($urandom);
         nosp    = NCH'($urandom) | NCH'($urandom);
         lk_held = $urandom_range(0, 1) == 1;
         lk_id   = IDW'($urandom);
         if ($urandom_range(0, 3) == 0) nosp = '1;
         tick("R5 R7 random");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule